// File: doc/BRIEF.md
# Programmable Sync Edge Detector

This block turns the free-running horizontal and vertical sync inputs of a video source into clean, single-cycle timing events in the dot clock domain. Each input may arrive active-high or active-low. A single polarity bit maps both inputs onto an internal "pulse active" level before anything else looks at them. Both inputs then cross into the clock domain through a short flop chain.

A line start is raised on whichever HSYNC edge configuration picks. A frame start comes from a two-step handshake. First a chosen VSYNC edge arms the detector. Then the next chosen HSYNC edge fires the frame-start pulse and disarms it. One setting combination moves the frame-start point to the HSYNC leading edge plus ten dot clocks.

A dot counter restarts at every line start. It opens a horizontal active window between a back-porch limit and a front-porch limit, both counted in pairs of dots. A hold output follows the synchronised HSYNC pulse, so neighbouring logic can pause its own work and refuse RAM writes while the pulse lasts.

Top module: `sync_edge_unit`

## Requirements
- R1: With `cfg_pos_pol` = 1 a sync pulse is the high level of its input; with `cfg_pos_pol` = 0 it is the low level. All edge detection works on this normalised level, so "leading" always means entering the pulse and "trailing" means leaving it.
- R2: `h_start` is high for exactly one clock cycle. That cycle follows the third rising clock edge after the selected HSYNC input transition.
- R3: `cfg_h_lead` = 1 starts a line on the HSYNC leading edge. `cfg_h_lead` = 0 starts it on the trailing edge. The other edge starts nothing.
- R4: `cfg_v_trail` = 0 arms vertical detection on the VSYNC leading edge, and `cfg_v_trail` = 1 on the trailing edge. The unselected VSYNC edge does not arm.
- R5: While armed, the next HSYNC edge chosen by `cfg_vh_trail` (0 leading, 1 trailing) raises `v_start` for one cycle, with the same latency as R2.
- R6: When `cfg_v_trail`, `cfg_vh_trail` and `cfg_h_lead` are all 1, `v_start` is raised 10 clock cycles later than the HSYNC leading-edge point of R5.
- R7: Qualification clears the armed state. Further HSYNC edges raise no `v_start` until a new selected VSYNC edge arrives.
- R8: The dot count is 0 in the `h_start` cycle and rises by one each cycle. `h_active` is high while the count lies in [2·`cfg_back_porch`, 2·`cfg_front_porch`).
- R9: With `cfg_back_porch` = 0 and a nonzero front porch, `h_active` is high in the `h_start` cycle itself. With `cfg_front_porch` ≤ `cfg_back_porch`, `h_active` never rises.
- R10: `line_hold` equals the normalised, synchronised HSYNC level, with the same latency as R2. It stays high for as many cycles as the input pulse lasts.
- R11: While `rst_n` is low, all outputs are low. Reset also clears the armed state, so a VSYNC edge seen before reset cannot produce a `v_start` afterwards.
- R12: A new line start inside an open window restarts the dot count from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| cfg_pos_pol | input | 1 | 1: sync pulses are high; 0: sync pulses are low |
| cfg_v_trail | input | 1 | VSYNC edge that arms: 0 leading, 1 trailing |
| cfg_vh_trail | input | 1 | HSYNC edge that qualifies a frame: 0 leading, 1 trailing |
| cfg_h_lead | input | 1 | HSYNC edge that starts a line: 0 trailing, 1 leading |
| cfg_back_porch | input | 6 | Window start, in units of 2 dots |
| cfg_front_porch | input | 9 | Window end, in units of 2 dots |
| h_start | output | 1 | One-cycle line-start pulse |
| v_start | output | 1 | One-cycle frame-start pulse |
| h_active | output | 1 | Horizontal active window |
| line_hold | output | 1 | High while the synchronised HSYNC pulse lasts |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a ten-cycle delay for the special vertical mode, and porch fields of 6 and 9 bits. With these values every latency is a small fixed number of cycles: 3 for normal events and 13 for the delayed frame start. The bench can therefore predict the exact cycle of every pulse. Short porch values keep each window within a few dozen cycles. Both polarities, all edge choices, zero and inverted porch pairs, and a line restart in mid-window all fit within one short run.

// File: rtl/sed_pkg.sv
package sed_pkg;

  localparam int CH_H   = 0;
  localparam int CH_V   = 1;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic lead;
    logic trail;
  } sed_edges_t;

  function automatic logic sed_pick(input sed_edges_t e, input logic use_trail);
    return use_trail ? e.trail : e.lead;
  endfunction

endpackage

// File: rtl/sed_sync.sv
module sed_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sed_edge.sv
module sed_edge
  import sed_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic       [WIDTH-1:0] lvl,
  output logic       [WIDTH-1:0] lvl_q,
  output sed_edges_t [WIDTH-1:0] edges
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  genvar c;
  generate
    for (c = 0; c < WIDTH; c++) begin : g_ch
      assign edges[c].lead  =  lvl[c] & ~lvl_q[c];
      assign edges[c].trail = ~lvl[c] &  lvl_q[c];
    end
  endgenerate

endmodule

// File: rtl/sed_vqual.sv
module sed_vqual #(
  parameter int DLY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_ev,
  input  logic qual_ev,
  input  logic dly_mode,
  output logic v_start
);

  localparam int DLY_W = $clog2(DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DLY);
  localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

  logic             armed_q, armed_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             fire_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    fire_d  = 1'b0;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - DLY_ONE;
      if (cnt_q == DLY_ONE) fire_d = 1'b1;
    end
    if (armed_q && qual_ev) begin
      armed_d = 1'b0;
      if (dly_mode) cnt_d  = DLY_LOAD;
      else          fire_d = 1'b1;
    end
    if (arm_ev) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      v_start <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      v_start <= fire_d;
    end
  end

endmodule

// File: rtl/sed_hwin.sv
module sed_hwin #(
  parameter int BP_W = 6,
  parameter int FP_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_ev,
  input  logic [BP_W-1:0] back_porch,
  input  logic [FP_W-1:0] front_porch,
  output logic            h_start,
  output logic            h_active
);

  localparam int CNT_W = ((FP_W > BP_W) ? FP_W : BP_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] open_lim, close_lim;

  assign open_lim  = CNT_W'({back_porch, 1'b0});
  assign close_lim = CNT_W'({front_porch, 1'b0});
  assign cnt_en    = run_q && (cnt_q != CNT_MAX);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (line_ev) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      h_start <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      h_start <= line_ev;
    end
  end

  assign h_active = run_q && (cnt_q >= open_lim) && (cnt_q < close_lim);

endmodule

// File: rtl/sync_edge_unit.sv
module sync_edge_unit
  import sed_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BP_W        = 6,
  parameter int FP_W        = 9,
  parameter int VDLY        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync_in,
  input  logic            vsync_in,
  input  logic            cfg_pos_pol,
  input  logic            cfg_v_trail,
  input  logic            cfg_vh_trail,
  input  logic            cfg_h_lead,
  input  logic [BP_W-1:0] cfg_back_porch,
  input  logic [FP_W-1:0] cfg_front_porch,
  output logic            h_start,
  output logic            v_start,
  output logic            h_active,
  output logic            line_hold
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [NUM_CH-1:0] raw_lvl, norm_lvl, sync_lvl, prev_lvl;
  sed_edges_t [NUM_CH-1:0] edges;
  logic              line_ev, arm_ev, qual_ev, dly_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign raw_lvl[CH_H] = hsync_in;
  assign raw_lvl[CH_V] = vsync_in;
  assign norm_lvl      = raw_lvl ^ {NUM_CH{~cfg_pos_pol}};

  sed_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (norm_lvl),
    .q     (sync_lvl)
  );

  sed_edge #(.WIDTH(NUM_CH)) u_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lvl   (sync_lvl),
    .lvl_q (prev_lvl),
    .edges (edges)
  );

  assign dly_mode = cfg_v_trail & cfg_vh_trail & cfg_h_lead;
  assign line_ev  = sed_pick(edges[CH_H], ~cfg_h_lead);
  assign arm_ev   = sed_pick(edges[CH_V], cfg_v_trail);
  assign qual_ev  = dly_mode ? edges[CH_H].lead : sed_pick(edges[CH_H], cfg_vh_trail);

  sed_vqual #(.DLY(VDLY)) u_vqual (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .arm_ev   (arm_ev),
    .qual_ev  (qual_ev),
    .dly_mode (dly_mode),
    .v_start  (v_start)
  );

  sed_hwin #(.BP_W(BP_W), .FP_W(FP_W)) u_hwin (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .line_ev     (line_ev),
    .back_porch  (cfg_back_porch),
    .front_porch (cfg_front_porch),
    .h_start     (h_start),
    .h_active    (h_active)
  );

  assign line_hold = prev_lvl[CH_H];

endmodule

// File: rtl/sync_edge_unit_chk.sv
module sync_edge_unit_chk #(
  parameter int BP_W = 6,
  parameter int FP_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_h_lead,
  input logic [BP_W-1:0] cfg_back_porch,
  input logic [FP_W-1:0] cfg_front_porch,
  input logic            h_start,
  input logic            v_start,
  input logic            h_active,
  input logic            line_hold
);

  // R2: line-start pulse lasts one cycle
  p_hstart_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_start |=> !h_start);

  // R5: frame-start pulse lasts one cycle
  p_vstart_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    v_start |=> !v_start);

  // R3: the hold level matches the edge that started the line
  p_hold_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_start |-> (line_hold == $past(cfg_h_lead)));

  // R8: a nonzero back porch keeps the window shut at line start
  p_porch_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_start && (cfg_back_porch != '0)) |-> !h_active);

  // R9: a zero back porch opens the window at line start
  p_zero_porch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_start && (cfg_back_porch == '0) && (cfg_front_porch != '0)) |-> h_active);

endmodule

bind sync_edge_unit sync_edge_unit_chk #(.BP_W(BP_W), .FP_W(FP_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_h_lead      (cfg_h_lead),
  .cfg_back_porch  (cfg_back_porch),
  .cfg_front_porch (cfg_front_porch),
  .h_start         (h_start),
  .v_start         (v_start),
  .h_active        (h_active),
  .line_hold       (line_hold)
);

// File: tb/sync_edge_unit_tb.sv
module sync_edge_unit_tb;

  localparam int HW = 8;
  localparam int NV = 9;

  typedef struct packed {
    logic       pol;
    logic       vtr;
    logic       vhtr;
    logic       hlead;
    logic [5:0] bp;
    logic [8:0] fp;
    logic [4:0] exh;
    logic [4:0] exv;
  } vec_t;

  // pol vtr vhtr hlead bp fp | expected h_start / v_start offset from HSYNC assert
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 6'd2, 9'd10, 5'd3,  5'd3 },
    '{1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 9'd5,  5'd3,  5'd3 },
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd3, 9'd12, 5'd11, 5'd11},
    '{1'b0, 1'b0, 1'b1, 1'b1, 6'd1, 9'd4,  5'd3,  5'd11},
    '{1'b1, 1'b1, 1'b0, 1'b0, 6'd4, 9'd20, 5'd11, 5'd3 },
    '{1'b1, 1'b1, 1'b1, 1'b1, 6'd2, 9'd8,  5'd3,  5'd13},
    '{1'b0, 1'b1, 1'b1, 1'b1, 6'd5, 9'd9,  5'd3,  5'd13},
    '{1'b1, 1'b0, 1'b1, 1'b1, 6'd6, 9'd6,  5'd3,  5'd11},
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'd3, 9'd2,  5'd11, 5'd11}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync_in, vsync_in;
  logic       cfg_pos_pol, cfg_v_trail, cfg_vh_trail, cfg_h_lead;
  logic [5:0] cfg_back_porch;
  logic [8:0] cfg_front_porch;
  logic       h_start, v_start, h_active, line_hold;

  always #4 clk = ~clk;

  sync_edge_unit u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .hsync_in        (hsync_in),
    .vsync_in        (vsync_in),
    .cfg_pos_pol     (cfg_pos_pol),
    .cfg_v_trail     (cfg_v_trail),
    .cfg_vh_trail    (cfg_vh_trail),
    .cfg_h_lead      (cfg_h_lead),
    .cfg_back_porch  (cfg_back_porch),
    .cfg_front_porch (cfg_front_porch),
    .h_start         (h_start),
    .v_start         (v_start),
    .h_active        (h_active),
    .line_hold       (line_hold)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  bit mon_on = 1'b0;
  int h_cnt, h_at, v_cnt, v_at, act_cnt, act_first, act_last, hold_cnt, hold_first;

  always @(negedge clk) begin
    if (mon_on) begin
      if (h_start) begin h_cnt++; h_at = cyc; end
      if (v_start) begin v_cnt++; v_at = cyc; end
      if (h_active) begin
        act_cnt++;
        if (act_first < 0) act_first = cyc;
        act_last = cyc;
      end
      if (line_hold) begin
        hold_cnt++;
        if (hold_first < 0) hold_first = cyc;
      end
    end
  end

  task automatic clr_mon();
    h_cnt = 0; h_at = -1; v_cnt = 0; v_at = -1;
    act_cnt = 0; act_first = -1; act_last = -1;
    hold_cnt = 0; hold_first = -1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic pol, input logic vtr, input logic vhtr,
                         input logic hlead, input logic [5:0] bp, input logic [8:0] fp);
    cfg_pos_pol     = pol;
    cfg_v_trail     = vtr;
    cfg_vh_trail    = vhtr;
    cfg_h_lead      = hlead;
    cfg_back_porch  = bp;
    cfg_front_porch = fp;
    hsync_in        = ~pol;
    vsync_in        = ~pol;
  endtask

  task automatic hs(input bit act);
    hsync_in = act ? cfg_pos_pol : ~cfg_pos_pol;
  endtask

  task automatic vs(input bit act);
    vsync_in = act ? cfg_pos_pol : ~cfg_pos_pol;
  endtask

  task automatic hs_pulse(input int width);
    hs(1'b1); step(width); hs(1'b0);
  endtask

  task automatic vs_pulse();
    vs(1'b1); step(4); vs(1'b0); step(6);
  endtask

  task automatic run_vec(input vec_t v);
    int t0, len;
    bit special;
    set_cfg(v.pol, v.vtr, v.vhtr, v.hlead, v.bp, v.fp);
    step(20);
    clr_mon();
    vs_pulse();
    t0 = cyc;
    hs_pulse(HW);
    step(2 * int'(v.fp) + 30);
    special = v.vtr & v.vhtr & v.hlead;
    len = (v.fp > 9'(v.bp)) ? 2 * (int'(v.fp) - int'(v.bp)) : 0;
    chk("R3", "line starts", h_cnt, 1);
    chk("R2", "h_start cycle", h_at, t0 + int'(v.exh));
    if (special) begin
      chk("R6", "frame starts", v_cnt, 1);
      chk("R6", "v_start cycle", v_at, t0 + int'(v.exv));
    end else begin
      chk("R5", "frame starts", v_cnt, 1);
      chk("R5", "v_start cycle", v_at, t0 + int'(v.exv));
    end
    if (len == 0 || v.bp == 6'd0) chk("R9", "active length", act_cnt, len);
    else                          chk("R8", "active length", act_cnt, len);
    if (len > 0) chk("R8", "active first", act_first, t0 + int'(v.exh) + 2 * int'(v.bp));
    chk("R10", "hold length", hold_cnt, HW);
    chk("R1", "hold first", hold_first, t0 + 3);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    int t0;
    rst_n = 1'b0;
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 6'd2, 9'd10);
    clr_mon();
    mon_on = 1'b1;
    step(3);
    chk("R11", "h_start in reset", int'(h_start), 0);
    chk("R11", "v_start in reset", int'(v_start), 0);
    chk("R11", "h_active in reset", int'(h_active), 0);
    chk("R11", "line_hold in reset", int'(line_hold), 0);
    rst_n = 1'b1;
    step(6);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R4: the unselected VSYNC edge does not arm
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 6'd1, 9'd4);
    step(20);
    clr_mon();
    vs(1'b1); step(6);
    hs_pulse(HW); step(20);
    chk("R4", "no frame after leading VSYNC", v_cnt, 0);
    vs(1'b0); step(6);
    t0 = cyc;
    hs_pulse(HW); step(20);
    chk("R4", "frame after trailing VSYNC", v_cnt, 1);
    chk("R4", "v_start cycle", v_at, t0 + 3);

    // R7: arm consumed by the first qualifying edge
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 6'd1, 9'd4);
    step(20);
    clr_mon();
    vs_pulse();
    hs_pulse(HW); step(20);
    hs_pulse(HW); step(20);
    chk("R7", "line starts", h_cnt, 2);
    chk("R7", "single frame start", v_cnt, 1);

    // R11: reset clears the armed state
    clr_mon();
    vs_pulse();
    rst_n = 1'b0;
    step(3);
    chk("R11", "v_start held low", int'(v_start), 0);
    rst_n = 1'b1;
    step(6);
    clr_mon();
    hs_pulse(HW); step(30);
    chk("R11", "line start after reset", h_cnt, 1);
    chk("R11", "no frame after reset", v_cnt, 0);

    // R12: a second line start restarts the window
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 6'd3, 9'd20);
    step(20);
    clr_mon();
    t0 = cyc;
    hs_pulse(4);
    step(8);
    hs(1'b1);
    step(4);
    chk("R12", "window closed after restart", int'(h_active), 0);
    hs(1'b0);
    step(80);
    chk("R12", "line starts", h_cnt, 2);
    chk("R12", "active first", act_first, t0 + 9);
    chk("R12", "active total", act_cnt, 40);
    chk("R12", "active last", act_last, t0 + 54);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 100000);
      report();
      $finish;
    end
  end

endmodule